// File: doc/BRIEF.md
# Power Domain Sequencer

This controller moves one switchable power domain between three resting conditions: fully on, retention (state saved, supply removed) and off (supply removed, nothing kept). Software asks for sleep with a chosen depth, or for wake. Hardware can also wake the domain. A hardware wake comes from any interrupt line whose own enable bit is set, or from a timer expiry. Every step that touches the domain is a handshake: bus quiesce, state save and restore, and the power switch with its power-good feedback. Each handshake is completed before the next step begins.

Entry runs in this order: quiesce, optional save, clock gate, power cut. Exit runs the reverse: power up, clocks and reset release, optional restore, isolation release. A wake that arrives during entry is remembered. The sequencer finishes the handshake in progress and then turns back toward the on condition. A programmable per-step limit turns a stuck handshake into a latched error, with the domain isolated and unpowered.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, `state_o`=0 (on). `clk_en_o`, `pwr_en_o` and `dom_rst_no` are 1. `quiesce_req_o`, `save_req_o`, `restore_req_o`, `iso_o`, `done_o` and `err_o` are 0.
- R2: A sleep request accepted in the on condition raises `quiesce_req_o` and `iso_o` on the next cycle. `state_o` reads 3 (busy) and clocks and power stay on until `quiesce_ack_i`.
- R3: With `sw_sleep_ret_i`=1 latched, `save_req_o` is raised after the quiesce acknowledge, with clocks still running. It is held until `ret_ack_i`.
- R4: Clocks are gated for one cycle with power still on. Then `pwr_en_o` and `dom_rst_no` drop, and the step waits for `pwr_good_i`=0. After that `state_o` shows 1 (retention) or 2 (off).
- R5: With `sw_sleep_ret_i`=0, no save is issued on entry and no restore is issued on exit.
- R6: Exit raises `pwr_en_o` and waits for `pwr_good_i`=1. On the next cycle `clk_en_o` and `dom_rst_no` go high. `restore_req_o` follows only when leaving retention and is held until `ret_ack_i`. Then the on condition is reached.
- R7: `iso_o` is 1 whenever `state_o` is not 0. Isolation is released only in the cycle the on condition is entered, after any restore.
- R8: In retention or off, `sw_wake_i`, `timer_exp_i`, or `irq_i[k]` with `irq_wake_en_i[k]`=1 starts exit on the next cycle. An `irq_i[k]` with enable bit k at 0 has no effect.
- R9: A wake during entry lets the current handshake finish. If power was not yet cut, the domain returns to on without a power drop or restore. If the wake arrives during the power-cut step, the full exit sequence follows once `pwr_good_i` falls.
- R10: A hardware wake in the same cycle as `sw_sleep_i` wins: the sleep request is dropped and the domain stays on.
- R11: A handshake step still waiting after being shown for `step_limit_i`+1 cycles enters a latched error on the next edge. The error state has `err_o`=1, `iso_o`=1, `quiesce_req_o`=1, `state_o`=3, and clocks, power and domain reset de-asserted. It holds until reset. A limit of 0 disables the timeout.
- R12: `done_o` is a one-cycle pulse in the first cycle `state_o` shows a newly reached on, retention or off condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_sleep_i | input | 1 | Software sleep request (sampled in on condition) |
| sw_sleep_ret_i | input | 1 | Sleep depth: 1 retention, 0 off |
| sw_wake_i | input | 1 | Software wake request |
| irq_i | input | N_IRQ | Interrupt lines |
| irq_wake_en_i | input | N_IRQ | Per-line wake enable |
| timer_exp_i | input | 1 | Wake timer expiry |
| step_limit_i | input | TMO_W | Handshake timeout in cycles, 0 disables |
| quiesce_req_o | output | 1 | Bus quiesce request |
| quiesce_ack_i | input | 1 | Bus quiesce acknowledge |
| save_req_o | output | 1 | Retention save request |
| restore_req_o | output | 1 | Retention restore request |
| ret_ack_i | input | 1 | Save/restore acknowledge |
| clk_en_o | output | 1 | Domain clock enable |
| iso_o | output | 1 | Output isolation enable |
| pwr_en_o | output | 1 | Power switch enable |
| pwr_good_i | input | 1 | Domain supply good |
| dom_rst_no | output | 1 | Domain reset, active low |
| state_o | output | 2 | 0 on, 1 retention, 2 off, 3 busy/error |
| done_o | output | 1 | Target reached pulse |
| err_o | output | 1 | Handshake timeout error |

## Verification
The hardest case to reach is a wake that lands inside an entry handshake. The wake must be recorded while the handshake is still open, and the sequencer must turn around only after that handshake closes. The bench makes this happen by holding back the responder for quiesce or power-good and injecting a wake. It then releases the responder and checks that the domain goes back on. Power must not drop in the first case, and in the second the full power-up path must follow. The timeout path is reached in the same way: the acknowledge is withheld beyond the programmed limit. The bench also holds it past a zero limit to show that a zero limit never trips.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    S_ON, S_QUIESCE, S_SAVE, S_CLKOFF, S_PWROFF,
    S_RET, S_OFF, S_PWRON, S_CLKON, S_RESTORE, S_ERR
  } seq_state_e;

  localparam logic [1:0] VIS_ON   = 2'd0;
  localparam logic [1:0] VIS_RET  = 2'd1;
  localparam logic [1:0] VIS_OFF  = 2'd2;
  localparam logic [1:0] VIS_BUSY = 2'd3;

  function automatic logic is_entry(seq_state_e s);
    return (s == S_QUIESCE) || (s == S_SAVE) || (s == S_CLKOFF) || (s == S_PWROFF);
  endfunction

  function automatic logic is_rest(seq_state_e s);
    return (s == S_ON) || (s == S_RET) || (s == S_OFF);
  endfunction

endpackage

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] wake_en_i,
  input  logic             timer_exp_i,
  input  logic             sw_wake_i,
  output logic             any_wake_o
);
  logic [N_IRQ-1:0] gated;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    assign gated[g] = irq_i[g] & wake_en_i[g];
  end

  assign any_wake_o = (|gated) | timer_exp_i | sw_wake_i;
endmodule

// File: rtl/pwr_step_tmr.sv
module pwr_step_tmr #(
  parameter int TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (limit_i != '0) && (cnt_q == limit_i);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_sleep_i,
  input  logic       sleep_ret_i,
  input  logic       any_wake_i,
  input  logic       quiesce_ack_i,
  input  logic       ret_ack_i,
  input  logic       pwr_good_i,
  input  logic       step_expired_i,
  output logic       step_restart_o,
  output logic       quiesce_req_o,
  output logic       save_req_o,
  output logic       restore_req_o,
  output logic       clk_en_o,
  output logic       iso_o,
  output logic       pwr_en_o,
  output logic       dom_rst_no,
  output logic [1:0] state_o,
  output logic       done_o,
  output logic       err_o
);
  seq_state_e state_q, state_d;
  logic tgt_ret_q, tgt_ret_d;
  logic pend_q, pend_d;
  logic need_rst_q, need_rst_d;
  logic done_q;
  logic abort;

  assign abort = pend_q | any_wake_i;

  always_comb begin
    state_d    = state_q;
    tgt_ret_d  = tgt_ret_q;
    need_rst_d = need_rst_q;
    case (state_q)
      S_ON:
        if (sw_sleep_i && !any_wake_i) begin
          state_d   = S_QUIESCE;
          tgt_ret_d = sleep_ret_i;
        end
      S_QUIESCE:
        if (quiesce_ack_i)       state_d = abort ? S_ON : (tgt_ret_q ? S_SAVE : S_CLKOFF);
        else if (step_expired_i) state_d = S_ERR;
      S_SAVE:
        if (ret_ack_i)           state_d = abort ? S_ON : S_CLKOFF;
        else if (step_expired_i) state_d = S_ERR;
      S_CLKOFF:
        state_d = abort ? S_CLKON : S_PWROFF;
      S_PWROFF:
        if (!pwr_good_i) begin
          state_d    = abort ? S_PWRON : (tgt_ret_q ? S_RET : S_OFF);
          need_rst_d = tgt_ret_q;
        end else if (step_expired_i) state_d = S_ERR;
      S_RET, S_OFF:
        if (any_wake_i) state_d = S_PWRON;
      S_PWRON:
        if (pwr_good_i)          state_d = S_CLKON;
        else if (step_expired_i) state_d = S_ERR;
      S_CLKON:
        state_d = need_rst_q ? S_RESTORE : S_ON;
      S_RESTORE:
        if (ret_ack_i) begin
          state_d    = S_ON;
          need_rst_d = 1'b0;
        end else if (step_expired_i) state_d = S_ERR;
      default:
        state_d = S_ERR;
    endcase
  end

  // wake seen during entry is kept until the sequence turns around
  assign pend_d = is_entry(state_d) && (pend_q || any_wake_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_ON;
      tgt_ret_q  <= 1'b0;
      pend_q     <= 1'b0;
      need_rst_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      tgt_ret_q  <= tgt_ret_d;
      pend_q     <= pend_d;
      need_rst_q <= need_rst_d;
      done_q     <= (state_d != state_q) && is_rest(state_d);
    end
  end

  assign step_restart_o = (state_d != state_q);

  assign quiesce_req_o = (state_q != S_ON);
  assign iso_o         = (state_q != S_ON);
  assign save_req_o    = (state_q == S_SAVE);
  assign restore_req_o = (state_q == S_RESTORE);
  assign clk_en_o      = state_q inside {S_ON, S_QUIESCE, S_SAVE, S_CLKON, S_RESTORE};
  assign pwr_en_o      = !(state_q inside {S_PWROFF, S_RET, S_OFF, S_ERR});
  assign dom_rst_no    = !(state_q inside {S_PWROFF, S_RET, S_OFF, S_PWRON, S_ERR});
  assign err_o         = (state_q == S_ERR);
  assign done_o        = done_q;

  always_comb begin
    case (state_q)
      S_ON:    state_o = VIS_ON;
      S_RET:   state_o = VIS_RET;
      S_OFF:   state_o = VIS_OFF;
      default: state_o = VIS_BUSY;
    endcase
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int N_IRQ = 8,
  parameter int TMO_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_sleep_i,
  input  logic             sw_sleep_ret_i,
  input  logic             sw_wake_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_wake_en_i,
  input  logic             timer_exp_i,
  input  logic [TMO_W-1:0] step_limit_i,
  output logic             quiesce_req_o,
  input  logic             quiesce_ack_i,
  output logic             save_req_o,
  output logic             restore_req_o,
  input  logic             ret_ack_i,
  output logic             clk_en_o,
  output logic             iso_o,
  output logic             pwr_en_o,
  input  logic             pwr_good_i,
  output logic             dom_rst_no,
  output logic [1:0]       state_o,
  output logic             done_o,
  output logic             err_o
);
  logic any_wake;
  logic step_restart;
  logic step_expired;

  pwr_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .irq_i       (irq_i),
    .wake_en_i   (irq_wake_en_i),
    .timer_exp_i (timer_exp_i),
    .sw_wake_i   (sw_wake_i),
    .any_wake_o  (any_wake)
  );

  pwr_step_tmr #(.TW(TMO_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (step_restart),
    .limit_i   (step_limit_i),
    .expired_o (step_expired)
  );

  pwr_seq_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sw_sleep_i     (sw_sleep_i),
    .sleep_ret_i    (sw_sleep_ret_i),
    .any_wake_i     (any_wake),
    .quiesce_ack_i  (quiesce_ack_i),
    .ret_ack_i      (ret_ack_i),
    .pwr_good_i     (pwr_good_i),
    .step_expired_i (step_expired),
    .step_restart_o (step_restart),
    .quiesce_req_o  (quiesce_req_o),
    .save_req_o     (save_req_o),
    .restore_req_o  (restore_req_o),
    .clk_en_o       (clk_en_o),
    .iso_o          (iso_o),
    .pwr_en_o       (pwr_en_o),
    .dom_rst_no     (dom_rst_no),
    .state_o        (state_o),
    .done_o         (done_o),
    .err_o          (err_o)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       quiesce_req_o,
  input logic       save_req_o,
  input logic       clk_en_o,
  input logic       iso_o,
  input logic       pwr_en_o,
  input logic       pwr_good_i,
  input logic       dom_rst_no,
  input logic [1:0] state_o,
  input logic       done_o,
  input logic       err_o
);
  // R2
  quiesce_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> quiesce_req_o && clk_en_o && pwr_en_o);

  // R3
  save_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |-> quiesce_req_o && clk_en_o && pwr_en_o);

  // R4
  gate_before_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> !clk_en_o);

  // R6
  pg_before_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dom_rst_no) |-> $past(pwr_good_i));

  // R7
  iso_only_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_o |-> (state_o == 2'd0) && clk_en_o && pwr_en_o);

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && iso_o && !pwr_en_o);

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  done_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_o != 2'd3);
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_seq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .quiesce_req_o (quiesce_req_o),
  .save_req_o    (save_req_o),
  .clk_en_o      (clk_en_o),
  .iso_o         (iso_o),
  .pwr_en_o      (pwr_en_o),
  .pwr_good_i    (pwr_good_i),
  .dom_rst_no    (dom_rst_no),
  .state_o       (state_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NI = 8;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_sleep = 1'b0, sw_ret = 1'b0, sw_wake = 1'b0, timer_exp = 1'b0;
  logic [NI-1:0] irq = '0, irq_en = '0;
  logic [TW-1:0] limit = '0;
  logic qack = 1'b0, ret_ack = 1'b0, pgood = 1'b1;
  logic q_hold = 1'b0, r_hold = 1'b0, pg_hold = 1'b0;
  logic quiesce_req_o, save_req_o, restore_req_o, clk_en_o, iso_o, pwr_en_o;
  logic dom_rst_no, done_o, err_o;
  logic [1:0] state_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_seq_ctrl #(.N_IRQ(NI), .TMO_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_sleep_i(sw_sleep), .sw_sleep_ret_i(sw_ret),
    .sw_wake_i(sw_wake), .irq_i(irq), .irq_wake_en_i(irq_en), .timer_exp_i(timer_exp),
    .step_limit_i(limit), .quiesce_req_o(quiesce_req_o), .quiesce_ack_i(qack),
    .save_req_o(save_req_o), .restore_req_o(restore_req_o), .ret_ack_i(ret_ack),
    .clk_en_o(clk_en_o), .iso_o(iso_o), .pwr_en_o(pwr_en_o), .pwr_good_i(pgood),
    .dom_rst_no(dom_rst_no), .state_o(state_o), .done_o(done_o), .err_o(err_o)
  );

  // domain model: answers one step after the outputs settle
  initial forever begin
    @(negedge clk);
    #1;
    qack    = quiesce_req_o && !q_hold;
    ret_ack = (save_req_o || restore_req_o) && !r_hold;
    if (!pg_hold) pgood = pwr_en_o;
  end

  function automatic logic [10:0] v(input logic [1:0] st, input logic q, s, r, c, i, p, n, d, e);
    return {st, q, s, r, c, i, p, n, d, e};
  endfunction

  localparam logic [10:0] ONV  = {2'd0, 9'b000_1011_00};
  localparam logic [10:0] ONDV = {2'd0, 9'b000_1011_10};

  task automatic chk(input string r, input logic [10:0] exp);
    logic [10:0] act;
    act = {state_o, quiesce_req_o, save_req_o, restore_req_o, clk_en_o, iso_o,
           pwr_en_o, dom_rst_no, done_o, err_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_vis(input string r, input logic [1:0] st);
    for (int k = 0; k < 40; k++) begin
      if (state_o == st) break;
      tick();
    end
    n_chk++;
    if (state_o !== st) begin
      n_bad++;
      $display("FAIL %s: state %0d expected %0d", r, state_o, st);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    q_hold = 0; r_hold = 0; pg_hold = 0;
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic pulse_sleep(input logic ret);
    sw_sleep = 1'b1; sw_ret = ret;
    tick();
    sw_sleep = 1'b0;
  endtask

  task automatic pulse_wake();
    sw_wake = 1'b1;
    tick();
    sw_wake = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", ONV);
  endtask

  task automatic t_retention();
    pulse_sleep(1'b1);
    chk("R2 quiesce step", v(3,1,0,0,1,1,1,1,0,0));
    tick(); chk("R3 save step", v(3,1,1,0,1,1,1,1,0,0));
    tick(); chk("R4 clock gate", v(3,1,0,0,0,1,1,1,0,0));
    tick(); chk("R4 power cut", v(3,1,0,0,0,1,0,0,0,0));
    tick(); chk("R12 retention done", v(1,1,0,0,0,1,0,0,1,0));
    tick(); chk("R12 done single", v(1,1,0,0,0,1,0,0,0,0));
    pulse_wake();
    chk("R6 power up", v(3,1,0,0,0,1,1,0,0,0));
    tick(); chk("R6 clocks and reset", v(3,1,0,0,1,1,1,1,0,0));
    tick(); chk("R7 restore with iso", v(3,1,0,1,1,1,1,1,0,0));
    tick(); chk("R7 on after restore", ONDV);
    tick(); chk("R12 on steady", ONV);
  endtask

  task automatic t_off_irq();
    pulse_sleep(1'b0);
    chk("R2 quiesce off", v(3,1,0,0,1,1,1,1,0,0));
    tick(); chk("R5 no save", v(3,1,0,0,0,1,1,1,0,0));
    tick(); chk("R4 cut off", v(3,1,0,0,0,1,0,0,0,0));
    tick(); chk("R4 off done", v(2,1,0,0,0,1,0,0,1,0));
    irq = 8'h02; irq_en = 8'h01;
    repeat (3) begin
      tick(); chk("R8 masked irq ignored", v(2,1,0,0,0,1,0,0,0,0));
    end
    irq_en = 8'h03;
    tick(); irq = '0; irq_en = '0;
    chk("R8 enabled irq wakes", v(3,1,0,0,0,1,1,0,0,0));
    tick(); chk("R6 clocks back", v(3,1,0,0,1,1,1,1,0,0));
    tick(); chk("R5 no restore", ONDV);
  endtask

  task automatic t_timer_wake();
    pulse_sleep(1'b1);
    wait_vis("R4 reach retention", 2'd1);
    tick();
    timer_exp = 1'b1;
    tick(); timer_exp = 1'b0;
    chk("R8 timer wakes", v(3,1,0,0,0,1,1,0,0,0));
    wait_vis("R6 back on", 2'd0);
    tick();
  endtask

  task automatic t_abort_quiesce();
    q_hold = 1'b1;
    pulse_sleep(1'b1);
    chk("R9 held quiesce", v(3,1,0,0,1,1,1,1,0,0));
    pulse_wake();
    chk("R9 step not cut short", v(3,1,0,0,1,1,1,1,0,0));
    q_hold = 1'b0;
    tick(); chk("R9 back on without save", ONDV);
    tick();
  endtask

  task automatic t_abort_pwroff();
    pg_hold = 1'b1;
    pulse_sleep(1'b0);
    tick(); tick();
    chk("R9 power cut pending", v(3,1,0,0,0,1,0,0,0,0));
    pulse_wake();
    chk("R9 waits power-good low", v(3,1,0,0,0,1,0,0,0,0));
    pg_hold = 1'b0;
    tick(); chk("R9 reverses to power up", v(3,1,0,0,0,1,1,0,0,0));
    tick(); chk("R9 clocks after power", v(3,1,0,0,1,1,1,1,0,0));
    tick(); chk("R9 on after abort", ONDV);
    tick();
  endtask

  task automatic t_arbitration();
    sw_sleep = 1'b1; sw_ret = 1'b1; timer_exp = 1'b1;
    tick(); sw_sleep = 1'b0; timer_exp = 1'b0;
    chk("R10 timer beats sleep", ONV);
    sw_sleep = 1'b1; irq = 8'h80; irq_en = 8'h80;
    tick(); sw_sleep = 1'b0;
    chk("R10 irq beats sleep", ONV);
    irq = 8'h40;
    sw_sleep = 1'b1; sw_ret = 1'b0;
    tick(); sw_sleep = 1'b0; irq = '0; irq_en = '0;
    chk("R8 masked irq does not block", v(3,1,0,0,1,1,1,1,0,0));
    wait_vis("R4 reach off", 2'd2);
    pulse_wake();
    wait_vis("R6 on again", 2'd0);
    tick();
  endtask

  task automatic t_timeout();
    limit = '0; q_hold = 1'b1;
    pulse_sleep(1'b0);
    repeat (20) tick();
    chk("R11 zero limit never trips", v(3,1,0,0,1,1,1,1,0,0));
    q_hold = 1'b0;
    wait_vis("R11 recovers", 2'd2);
    pulse_wake();
    wait_vis("R11 on", 2'd0);
    tick();
    limit = 12'd4; q_hold = 1'b1;
    pulse_sleep(1'b1);
    repeat (4) tick();
    chk("R11 still waiting at limit", v(3,1,0,0,1,1,1,1,0,0));
    tick(); chk("R11 error entered", v(3,1,0,0,0,1,0,0,0,1));
    q_hold = 1'b0;
    repeat (3) tick();
    chk("R11 error latched", v(3,1,0,0,0,1,0,0,0,1));
    pulse_wake();
    chk("R11 wake ignored in error", v(3,1,0,0,0,1,0,0,0,1));
    limit = '0;
    do_reset();
    chk("R1 reset clears error", ONV);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_retention();
    t_off_irq();
    t_timer_wake();
    t_abort_quiesce();
    t_abort_pwroff();
    t_arbitration();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule